// File: doc/BRIEF.md
# Interrupt claim-complete arbiter

This block sits between a set of level-sensitive interrupt sources and a few target contexts, for example the privilege levels of one or more cores. For every context it holds, per source, a pending flag, a claimed flag and the priority value sampled when the source became pending. From that state it chooses the best candidate for the context and raises a request line while a candidate exists.

A context takes an interrupt with a claim read. The read returns the winning source number and marks that source as claimed, which hides it from later arbitration in that context. When the handler finishes, it writes the source number to the complete port, and the source may compete again. Source number 0 is reserved. It is never pending, and it is the value returned when no candidate exists.

Enable masks, per-source priorities and per-context thresholds come in as plain input vectors. The block registers the enable mask and the threshold so that it can detect enable edges. Register decode and edge-triggered gateways belong to the surrounding logic.

Top module: `irq_claim_arbiter`

## Requirements
- R1: After a synchronous reset, no request line is high, every claim read returns 0, and no source is pending or claimed.
- R2: Source 0 cannot become pending. Its enable bit and level input have no effect, and a claim read with no candidate returns 0 and changes nothing.
- R3: A source is a candidate in a context only if it is pending there, is not claimed there, and its sampled priority is strictly greater than that context's registered threshold.
- R4: Among candidates, the one with the largest sampled priority wins. A tie goes to the smallest source number.
- R5: The priority used for arbitration is the value on the priority input in the cycle the source became pending. Later changes on that input have no effect until the source becomes pending again.
- R6: A claim read returns the current winner in the same cycle. At the next edge that source becomes claimed, so the following reads return the next candidate.
- R7: A complete write clears the claimed flag of the given number only when that number is below NUM_IDS and enabled in that context. A complete write for any other number leaves all state unchanged.
- R8: A falling level clears the source's pending flag, claimed flag and sampled priority in every context. If a claim read of the same source falls in the same cycle, the clearing wins.
- R9: An enable bit that rises while the level is high makes the source pending, with its priority sampled. An enable bit that falls clears pending, claimed and sampled priority.
- R10: A context's request line is high exactly when a claim read in that cycle would return a nonzero number.
- R11: A source whose sampled priority equals the threshold raises no request. Lowering the threshold below that priority raises the request one cycle after the change.
- R12: Contexts are independent. Claiming or completing in one context does not alter another context's request or winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_level | input | NUM_IDS | Level of each source; bit 0 is ignored |
| src_prio | input | NUM_IDS*PW | Priority per source, source i at bits [i*PW +: PW] |
| ctx_en | input | NCTX*NUM_IDS | Enable mask, context c source i at bit c*NUM_IDS+i |
| ctx_thresh | input | NCTX*PW | Threshold per context |
| claim_rd | input | NCTX | Claim read strobe per context |
| cmpl_wr | input | NCTX | Complete write strobe per context |
| cmpl_id | input | NCTX*IDW | Source number being completed, per context |
| claim_id | output | NCTX*IDW | Winner returned during a claim read, 0 otherwise |
| irq_req | output | NCTX | Request line per context |

## Verification
A claimed flag that fails to clear shows up at the ports on the next cycle: the request line stays low, or later claim reads skip that number. A wrong sampled priority appears only as a wrong order of claim results, so the directed tests change the live priority after capture and compare the claim sequence. A pending flag that survives a falling level or a disable leaves the request line high one cycle after the event, so each of those events is followed by a check of the request line before any new stimulus.

// File: rtl/icc_pkg.sv
package icc_pkg;

  localparam int unsigned CMP_W = 16;

  // left side holds the lower source numbers, so equal priorities keep left
  function automatic logic left_wins(input logic vl, input logic [CMP_W-1:0] pl,
                                     input logic vr, input logic [CMP_W-1:0] pr);
    return vl && (!vr || (pl >= pr));
  endfunction

  function automatic logic above_thresh(input logic [CMP_W-1:0] p,
                                        input logic [CMP_W-1:0] t);
    return p > t;
  endfunction

endpackage

// File: rtl/icc_ctx_state.sv
module icc_ctx_state #(
  parameter int unsigned NUM_IDS = 24,
  parameter int unsigned PW      = 3,
  parameter int unsigned IDW     = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_IDS-1:0]    lvl_now,
  input  logic [NUM_IDS-1:0]    lvl_rise,
  input  logic [NUM_IDS-1:0]    lvl_fall,
  input  logic [NUM_IDS*PW-1:0] prio_flat,
  input  logic [NUM_IDS-1:0]    en_in,
  input  logic [PW-1:0]         thresh_in,
  input  logic                  claim_rd,
  input  logic [IDW-1:0]        win_id,
  input  logic                  cmpl_wr,
  input  logic [IDW-1:0]        cmpl_id,
  output logic [NUM_IDS-1:0]    pend_o,
  output logic [NUM_IDS-1:0]    clm_o,
  output logic [NUM_IDS-1:0]    elig_o,
  output logic [NUM_IDS*PW-1:0] cap_o,
  output logic [PW-1:0]         th_o,
  output logic [NUM_IDS-1:0]    claim_set_o
);
  import icc_pkg::*;

  logic [NUM_IDS-1:0] en_eff;
  logic [NUM_IDS-1:0] en_q;
  logic [PW-1:0]      th_q;

  always_comb begin
    en_eff    = en_in;
    en_eff[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      th_q <= '0;
    end else begin
      en_q <= en_eff;
      th_q <= thresh_in;
    end
  end

  assign th_o = th_q;

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_src
    logic          pend_q, clm_q;
    logic [PW-1:0] cap_q;
    logic          set_ev, clr_ev, claim_hit, cmpl_hit;

    assign set_ev    = (lvl_rise[i] & en_eff[i]) | (en_eff[i] & ~en_q[i] & lvl_now[i]);
    assign clr_ev    = lvl_fall[i] | (en_q[i] & ~en_eff[i]);
    assign claim_hit = claim_rd && (win_id == IDW'(i)) && (i != 0);
    assign cmpl_hit  = cmpl_wr && (cmpl_id == IDW'(i)) && en_eff[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
        clm_q  <= 1'b0;
        cap_q  <= '0;
      end else if (clr_ev) begin
        pend_q <= 1'b0;
        clm_q  <= 1'b0;
        cap_q  <= '0;
      end else begin
        if (set_ev) begin
          pend_q <= 1'b1;
          cap_q  <= prio_flat[i*PW +: PW];
        end
        if (claim_hit)     clm_q <= 1'b1;
        else if (cmpl_hit) clm_q <= 1'b0;
      end
    end

    assign pend_o[i]           = pend_q;
    assign clm_o[i]            = clm_q;
    assign cap_o[i*PW +: PW]   = cap_q;
    assign claim_set_o[i]      = claim_hit & ~clr_ev;
    assign elig_o[i]           = pend_q & ~clm_q &
                                 above_thresh(CMP_W'(cap_q), CMP_W'(th_q));
  end

endmodule

// File: rtl/icc_prio_tree.sv
module icc_prio_tree #(
  parameter int unsigned NUM_IDS = 24,
  parameter int unsigned PW      = 3,
  parameter int unsigned IDW     = 5
) (
  input  logic [NUM_IDS-1:0]    elig,
  input  logic [NUM_IDS*PW-1:0] cap,
  output logic [IDW-1:0]        win_id,
  output logic [PW-1:0]         win_prio
);
  import icc_pkg::*;

  localparam int unsigned LVLS   = $clog2(NUM_IDS);
  localparam int unsigned LEAVES = 1 << LVLS;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic           nv  [NODES];
  logic [PW-1:0]  np  [NODES];
  logic [IDW-1:0] nid [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_IDS) begin : g_real
      assign nv [LEAVES-1+i] = elig[i];
      assign np [LEAVES-1+i] = cap[i*PW +: PW];
      assign nid[LEAVES-1+i] = IDW'(i);
    end else begin : g_pad
      assign nv [LEAVES-1+i] = 1'b0;
      assign np [LEAVES-1+i] = '0;
      assign nid[LEAVES-1+i] = '0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic take_l;
    assign take_l = left_wins(nv[2*k+1], CMP_W'(np[2*k+1]),
                              nv[2*k+2], CMP_W'(np[2*k+2]));
    assign nv [k] = nv[2*k+1] | nv[2*k+2];
    assign np [k] = take_l ? np [2*k+1] : np [2*k+2];
    assign nid[k] = take_l ? nid[2*k+1] : nid[2*k+2];
  end

  assign win_id   = nv[0] ? nid[0] : '0;
  assign win_prio = nv[0] ? np[0]  : '0;

endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter #(
  parameter int unsigned NUM_IDS = 24,
  parameter int unsigned NCTX    = 2,
  parameter int unsigned PW      = 3,
  parameter int unsigned IDW     = $clog2(NUM_IDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_IDS-1:0]      src_level,
  input  logic [NUM_IDS*PW-1:0]   src_prio,
  input  logic [NCTX*NUM_IDS-1:0] ctx_en,
  input  logic [NCTX*PW-1:0]      ctx_thresh,
  input  logic [NCTX-1:0]         claim_rd,
  input  logic [NCTX-1:0]         cmpl_wr,
  input  logic [NCTX*IDW-1:0]     cmpl_id,
  output logic [NCTX*IDW-1:0]     claim_id,
  output logic [NCTX-1:0]         irq_req
);

  logic [NUM_IDS-1:0] lvl_now, lvl_q, lvl_rise, lvl_fall;

  always_comb begin
    lvl_now    = src_level;
    lvl_now[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_now;
  end

  assign lvl_rise = lvl_now & ~lvl_q;
  assign lvl_fall = ~lvl_now & lvl_q;

  // observation points shared by all contexts, flat per context
  logic [NCTX*NUM_IDS-1:0]    pend_all, clm_all, elig_all, claim_set_all;
  logic [NCTX*NUM_IDS*PW-1:0] cap_all;
  logic [NCTX*IDW-1:0]        win_all;
  logic [NCTX*PW-1:0]         winp_all, th_all;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    icc_ctx_state #(.NUM_IDS(NUM_IDS), .PW(PW), .IDW(IDW)) state_i (
      .clk        (clk),
      .rst        (rst),
      .lvl_now    (lvl_now),
      .lvl_rise   (lvl_rise),
      .lvl_fall   (lvl_fall),
      .prio_flat  (src_prio),
      .en_in      (ctx_en[c*NUM_IDS +: NUM_IDS]),
      .thresh_in  (ctx_thresh[c*PW +: PW]),
      .claim_rd   (claim_rd[c]),
      .win_id     (win_all[c*IDW +: IDW]),
      .cmpl_wr    (cmpl_wr[c]),
      .cmpl_id    (cmpl_id[c*IDW +: IDW]),
      .pend_o     (pend_all[c*NUM_IDS +: NUM_IDS]),
      .clm_o      (clm_all[c*NUM_IDS +: NUM_IDS]),
      .elig_o     (elig_all[c*NUM_IDS +: NUM_IDS]),
      .cap_o      (cap_all[c*NUM_IDS*PW +: NUM_IDS*PW]),
      .th_o       (th_all[c*PW +: PW]),
      .claim_set_o(claim_set_all[c*NUM_IDS +: NUM_IDS])
    );

    icc_prio_tree #(.NUM_IDS(NUM_IDS), .PW(PW), .IDW(IDW)) tree_i (
      .elig    (elig_all[c*NUM_IDS +: NUM_IDS]),
      .cap     (cap_all[c*NUM_IDS*PW +: NUM_IDS*PW]),
      .win_id  (win_all[c*IDW +: IDW]),
      .win_prio(winp_all[c*PW +: PW])
    );

    assign irq_req[c]              = (win_all[c*IDW +: IDW] != '0);
    assign claim_id[c*IDW +: IDW]  = claim_rd[c] ? win_all[c*IDW +: IDW] : '0;
  end

endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int unsigned NUM_IDS = 24,
  parameter int unsigned NCTX    = 2,
  parameter int unsigned PW      = 3,
  parameter int unsigned IDW     = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NCTX-1:0]         irq_req,
  input logic [NUM_IDS-1:0]      lvl_fall,
  input logic [NCTX*NUM_IDS-1:0] pend_all,
  input logic [NCTX*NUM_IDS-1:0] clm_all,
  input logic [NCTX*NUM_IDS-1:0] elig_all,
  input logic [NCTX*NUM_IDS-1:0] claim_set_all,
  input logic [NCTX*IDW-1:0]     win_all,
  input logic [NCTX*PW-1:0]      winp_all,
  input logic [NCTX*PW-1:0]      th_all
);

  for (genvar c = 0; c < NCTX; c++) begin : g_chk
    logic [NUM_IDS-1:0] pend_c, clm_c, elig_c;
    logic [IDW-1:0]     win_c;
    assign pend_c = pend_all[c*NUM_IDS +: NUM_IDS];
    assign clm_c  = clm_all[c*NUM_IDS +: NUM_IDS];
    assign elig_c = elig_all[c*NUM_IDS +: NUM_IDS];
    assign win_c  = win_all[c*IDW +: IDW];

    assert_id0_never_pending_R2: assert property (@(posedge clk) disable iff (rst)
      !pend_c[0]);

    assert_claimed_only_if_pending_R3: assert property (@(posedge clk) disable iff (rst)
      (clm_c & ~pend_c) == '0);

    assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (rst)
      (win_c != '0) |-> (((elig_c >> win_c) & NUM_IDS'(1)) != '0));

    assert_one_claim_per_read_R6: assert property (@(posedge clk) disable iff (rst)
      $onehot0(claim_set_all[c*NUM_IDS +: NUM_IDS]));

    assert_fall_clears_state_R8: assert property (@(posedge clk) disable iff (rst)
      (lvl_fall != '0) |=> (((pend_c | clm_c) & $past(lvl_fall)) == '0));

    assert_no_request_without_pending_R10: assert property (@(posedge clk) disable iff (rst)
      (pend_c == '0) |-> !irq_req[c]);

    assert_request_above_threshold_R11: assert property (@(posedge clk) disable iff (rst)
      irq_req[c] |-> (winp_all[c*PW +: PW] > th_all[c*PW +: PW]));
  end

endmodule

bind irq_claim_arbiter icc_checker #(
  .NUM_IDS(NUM_IDS), .NCTX(NCTX), .PW(PW), .IDW(IDW)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .irq_req      (irq_req),
  .lvl_fall     (lvl_fall),
  .pend_all     (pend_all),
  .clm_all      (clm_all),
  .elig_all     (elig_all),
  .claim_set_all(claim_set_all),
  .win_all      (win_all),
  .winp_all     (winp_all),
  .th_all       (th_all)
);

// File: tb/irq_claim_arbiter_tb.sv
module irq_claim_arbiter_tb_top;
  localparam int NI  = 24;
  localparam int NC  = 2;
  localparam int PW  = 3;
  localparam int IDW = 5;

  logic                 clk = 1'b0;
  logic                 rst;
  logic [NI-1:0]        src_level;
  logic [NI*PW-1:0]     src_prio;
  logic [NC*NI-1:0]     ctx_en;
  logic [NC*PW-1:0]     ctx_thresh;
  logic [NC-1:0]        claim_rd, cmpl_wr;
  logic [NC*IDW-1:0]    cmpl_id;
  logic [NC*IDW-1:0]    claim_id;
  logic [NC-1:0]        irq_req;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5ns clk = ~clk;

  irq_claim_arbiter #(.NUM_IDS(NI), .NCTX(NC), .PW(PW), .IDW(IDW)) dut_i (
    .clk(clk), .rst(rst), .src_level(src_level), .src_prio(src_prio),
    .ctx_en(ctx_en), .ctx_thresh(ctx_thresh), .claim_rd(claim_rd),
    .cmpl_wr(cmpl_wr), .cmpl_id(cmpl_id), .claim_id(claim_id), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    src_level = '0; src_prio = '0; ctx_en = '0; ctx_thresh = '0;
    claim_rd = '0; cmpl_wr = '0; cmpl_id = '0;
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic set_src(input int id, input bit lvl, input int p);
    src_level[id] = lvl;
    src_prio[id*PW +: PW] = PW'(p);
  endtask

  task automatic set_en(input int c, input int id, input bit v);
    ctx_en[c*NI + id] = v;
  endtask

  task automatic claim(input int c, output int id);
    claim_rd[c] = 1'b1;
    #1ns;
    id = int'(claim_id[c*IDW +: IDW]);
    tick();
    claim_rd[c] = 1'b0;
  endtask

  task automatic complete(input int c, input int id);
    cmpl_wr[c] = 1'b1;
    cmpl_id[c*IDW +: IDW] = IDW'(id);
    tick();
    cmpl_wr[c] = 1'b0;
  endtask

  task automatic t_reset();
    int id;
    do_reset();
    chk("R1 irq ctx0 after reset", int'(irq_req[0]), 0);
    chk("R1 irq ctx1 after reset", int'(irq_req[1]), 0);
    claim(0, id);
    chk("R1 claim after reset", id, 0);
  endtask

  task automatic t_id_zero();
    int id;
    do_reset();
    set_en(0, 0, 1'b1);
    set_src(0, 1'b1, 7);
    tick(); tick();
    chk("R2 source 0 raises nothing", int'(irq_req[0]), 0);
    claim(0, id);
    chk("R2 empty claim returns 0", id, 0);
    set_en(0, 6, 1'b1);
    set_src(6, 1'b1, 2);
    tick();
    chk("R2 empty claim changed nothing", int'(irq_req[0]), 1);
  endtask

  task automatic t_order();
    int id;
    do_reset();
    set_en(0, 3, 1'b1); set_en(0, 5, 1'b1); set_en(0, 9, 1'b1);
    set_src(3, 1'b1, 2); set_src(5, 1'b1, 6); set_src(9, 1'b1, 6);
    tick();
    chk("R10 irq ctx0 with candidates", int'(irq_req[0]), 1);
    chk("R12 irq ctx1 not enabled", int'(irq_req[1]), 0);
    claim(0, id); chk("R4 tie lowest number", id, 5);
    claim(0, id); chk("R6 claimed source hidden", id, 9);
    claim(0, id); chk("R4 lower priority last", id, 3);
    chk("R3 all claimed no request", int'(irq_req[0]), 0);
    claim(0, id); chk("R6 nothing left", id, 0);
    complete(0, 29);
    chk("R7 out-of-range complete ignored", int'(irq_req[0]), 0);
    complete(0, 7);
    chk("R7 disabled complete ignored", int'(irq_req[0]), 0);
    complete(0, 9);
    chk("R7 valid complete restores", int'(irq_req[0]), 1);
    claim(0, id); chk("R7 completed source claimable", id, 9);
  endtask

  task automatic t_capture();
    int id;
    do_reset();
    set_en(0, 4, 1'b1); set_en(0, 6, 1'b1);
    set_src(4, 1'b1, 1); set_src(6, 1'b1, 3);
    tick();
    set_src(4, 1'b1, 7);
    tick();
    claim(0, id); chk("R5 live priority change ignored", id, 6);
    complete(0, 6);
    src_level[4] = 1'b0; tick();
    src_level[4] = 1'b1; tick();
    claim(0, id); chk("R5 priority recaptured on new pending", id, 4);
  endtask

  task automatic t_level_fall();
    int id;
    do_reset();
    set_en(0, 2, 1'b1);
    set_src(2, 1'b1, 3);
    tick();
    claim(0, id); chk("R6 claim returns source", id, 2);
    chk("R6 request drops after claim", int'(irq_req[0]), 0);
    src_level[2] = 1'b0; tick();
    src_level[2] = 1'b1; tick();
    chk("R8 fall cleared claimed flag", int'(irq_req[0]), 1);
    claim_rd[0] = 1'b1;
    src_level[2] = 1'b0;
    #1ns;
    chk("R8 claim in fall cycle returns winner", int'(claim_id[IDW-1:0]), 2);
    tick();
    claim_rd[0] = 1'b0;
    chk("R8 fall clears pending", int'(irq_req[0]), 0);
    src_level[2] = 1'b1; tick();
    chk("R8 fall beat simultaneous claim", int'(irq_req[0]), 1);
  endtask

  task automatic t_enable();
    int id;
    do_reset();
    set_src(8, 1'b1, 4);
    tick();
    chk("R9 disabled source silent", int'(irq_req[0]), 0);
    set_en(0, 8, 1'b1); tick();
    chk("R9 enable rise with high level", int'(irq_req[0]), 1);
    claim(0, id); chk("R9 claim enabled source", id, 8);
    set_en(0, 8, 1'b0); tick();
    chk("R9 disable clears pending", int'(irq_req[0]), 0);
    set_en(0, 8, 1'b1); tick();
    chk("R9 re-enable, claimed was cleared", int'(irq_req[0]), 1);
  endtask

  task automatic t_threshold();
    int id;
    do_reset();
    ctx_thresh[PW-1:0] = PW'(3);
    set_en(0, 10, 1'b1);
    set_src(10, 1'b1, 3);
    tick();
    chk("R11 priority equal to threshold", int'(irq_req[0]), 0);
    claim(0, id); chk("R3 below-threshold not claimable", id, 0);
    ctx_thresh[PW-1:0] = PW'(2);
    chk("R11 threshold is registered", int'(irq_req[0]), 0);
    tick();
    chk("R11 lowered threshold raises", int'(irq_req[0]), 1);
  endtask

  task automatic t_contexts();
    int id;
    do_reset();
    set_en(0, 11, 1'b1); set_en(1, 11, 1'b1);
    set_src(11, 1'b1, 5);
    tick();
    claim(0, id); chk("R12 ctx0 claim", id, 11);
    chk("R12 ctx1 still requesting", int'(irq_req[1]), 1);
    claim(1, id); chk("R12 ctx1 claim", id, 11);
    complete(0, 11);
    chk("R12 ctx0 restored", int'(irq_req[0]), 1);
    chk("R12 ctx1 still claimed", int'(irq_req[1]), 0);
  endtask

  initial begin
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    t_id_zero();
    t_order();
    t_capture();
    t_level_fall();
    t_enable();
    t_threshold();
    t_contexts();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule